// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache Controller

This block is the data cache between a CPU load/store port and a word-wide memory port. It holds 8 Kbytes as four ways of 128 sets, with 16-byte lines of four 32-bit words. An address splits into a 4-bit byte offset (bits 3:0, with the word in bits 3:2), a 7-bit set index (bits 10:4) and a 21-bit tag (bits 31:11). Each request is looked up in all four ways of its set at once. A read hit, or a write hit in write-back mode, completes in the cycle the request is seen. A miss starts memory traffic.

On an allocating miss the controller picks a victim. This is the least recently used way of the set, or the least recently used of ways 0 and 1 when the lock input is high. If the victim is dirty, its four words are first written out to the victim's own address. The new line is then fetched as four single-word reads, word 0 first, and the request completes from the refilled line. In write-through mode every write becomes one memory write. A write miss then allocates nothing, and no line is ever marked dirty. A flash-invalidate input empties the cache and restarts the recency order. It writes nothing back.

The CPU holds a request stable until `cpu_ready` is seen. Each memory beat is a request held until the cycle in which `mem_ack` is high.

Top module: `cache_ctrl`

## Requirements
- R1: A read that hits while the controller is idle raises `cpu_ready` in the same cycle, with the addressed word on `cpu_rdata`, and issues no memory request.
- R2: A read miss to a clean or empty victim issues exactly four memory reads (`mem_be` = 4'b1111) to the line's word addresses base+0, +4, +8, +12 in that order. The request then completes with the requested word.
- R3: The victim of an allocating miss is the least recently used way of the set. Both hits and fills make a way most recent. After reset or invalidate the order from least to most recent is way 3, 2, 1, 0.
- R4: While `lock_en` is 1 the victim is never way 2 or way 3. It is the less recently used of ways 0 and 1.
- R5: Lines in ways 2 and 3 still hit while `lock_en` is 1, and those hits still refresh the recency order.
- R6: With `wb_mode` = 1, a write hit merges the bytes whose `cpu_be` bit i is set (bit i selects data bits 8i+7:8i), marks the line dirty, completes in the same cycle and makes no memory request. A write miss allocates the line and then performs the write.
- R7: A miss whose victim is dirty first writes that line's four words to its old word addresses in order 0 to 3. It then refills.
- R8: With `wb_mode` = 0, every write is one memory write with `mem_be` = `cpu_be` and completes on its acknowledge. A hit also updates the cached word. A miss leaves the cache unchanged, so a later read of that line misses.
- R9: `inval_all`, acted on while idle and taking priority over a request, clears every valid bit and restores the reset recency order. It issues no memory write.
- R10: Once raised, `mem_req`, `mem_we` and `mem_addr` hold steady until the cycle in which `mem_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_mode | input | 1 | 1: write-back, 0: write-through |
| lock_en | input | 1 | Keep ways 2 and 3 out of replacement |
| inval_all | input | 1 | Invalidate every line, no writeback |
| cpu_valid | input | 1 | CPU request present |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_be | input | 4 | Byte enables of a write |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1: memory write beat |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_be | output | 4 | Byte enables of the beat |
| mem_wdata | output | 32 | Write data of the beat |
| mem_ack | input | 1 | Memory beat accepted / read data valid |
| mem_rdata | input | 32 | Read data of a beat |

## Verification
A wrong tag, valid or recency entry shows up at the ports as a hit or miss on the wrong access. A hit that should have been a miss gives a same-cycle `cpu_ready` with stale data. A miss that should have been a hit gives a burst of memory reads, and the bench sees this on the very access that follows the corruption. A lost dirty bit only appears later, when that line is chosen as a victim: the four writeback beats are missing, and the old data is missing from memory once the eviction finishes. So the bench reaches deliberately for those evictions. A wrong victim choice shows up as a miss on a line that should have stayed resident, one to three accesses after the faulty fill.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int AW         = 32;
  localparam int DW         = 32;
  localparam int WAYS       = 4;
  localparam int SETS       = 128;
  localparam int LINE_WORDS = 4;

  localparam int BE_W  = DW / 8;
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);
  localparam int WRD_W = $clog2(LINE_WORDS);
  localparam int OFF_W = WRD_W + $clog2(BE_W);
  localparam int TAG_W = AW - SET_W - OFF_W;
  localparam int AGE_W = WAY_W;

  // ways that the lock input removes from replacement
  localparam logic [WAYS-1:0] LOCKABLE = WAYS'(4'b1100);

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FILL, S_WTHRU} st_t;

  function automatic logic [SET_W-1:0] set_of(input logic [AW-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1 -: TAG_W];
  endfunction

  function automatic logic [WRD_W-1:0] word_of(input logic [AW-1:0] a);
    return a[OFF_W-1 -: WRD_W];
  endfunction

  function automatic logic [DW-1:0] byte_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [BE_W-1:0] be);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < BE_W; i++)
      if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cache_lru.sv
module cache_lru
  import cache_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SET_W-1:0] set_idx,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             lock_en,
  output logic [WAY_W-1:0] victim
);
  // per set and way: age 0 = most recent, WAYS-1 = least recent
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] cur   [WAYS];
  logic [WAYS-1:0]  eligible;

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_way
      assign cur[gw]      = age_q[set_idx][gw];
      assign eligible[gw] = !(lock_en && LOCKABLE[gw]);
    end
  endgenerate

  always_comb begin
    logic             found;
    logic [AGE_W-1:0] best;
    victim = '0;
    best   = '0;
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (eligible[w] && (!found || cur[w] > best)) begin
        victim = WAY_W'(w);
        best   = cur[w];
        found  = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
    end else if (clr) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++)
        if (WAY_W'(w) == touch_way)        age_q[set_idx][w] <= '0;
        else if (cur[w] < cur[touch_way])  age_q[set_idx][w] <= cur[w] + 1'b1;
    end
  end
endmodule

// File: rtl/cache_tagdir.sv
module cache_tagdir
  import cache_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SET_W-1:0] set_idx,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  input  logic [WAY_W-1:0] sel_way,
  output logic [TAG_W-1:0] sel_tag,
  output logic             sel_valid,
  output logic             sel_dirty,
  input  logic             fill_we,
  input  logic             dirty_we
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAYS-1:0]  hv;

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_cmp
      assign hv[gw] = valid_q[set_idx][gw] && (tag_q[set_idx][gw] == cmp_tag);
    end
  endgenerate

  assign hit = |hv;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hv[w]) hit_way = WAY_W'(w);
  end

  assign sel_tag   = tag_q[set_idx][sel_way];
  assign sel_valid = valid_q[set_idx][sel_way];
  assign sel_dirty = dirty_q[set_idx][sel_way];

  always_ff @(posedge clk) begin
    if (fill_we) tag_q[set_idx][sel_way] <= cmp_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (clr) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (fill_we) begin
        valid_q[set_idx][sel_way] <= 1'b1;
        dirty_q[set_idx][sel_way] <= 1'b0;
      end
      if (dirty_we) dirty_q[set_idx][hit_way] <= 1'b1;
    end
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wb_mode,
  input  logic            lock_en,
  input  logic            inval_all,
  input  logic            cpu_valid,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [BE_W-1:0] cpu_be,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_ready,
  output logic [DW-1:0]   cpu_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [BE_W-1:0] mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata
);
  st_t              st_q;
  logic [WAY_W-1:0] vway_q;
  logic [WRD_W-1:0] beat_q;
  logic [DW-1:0]    data_q [WAYS][SETS][LINE_WORDS];

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] ctag;
  logic [WRD_W-1:0] cword;
  logic             hit, sel_valid, sel_dirty;
  logic [WAY_W-1:0] hit_way, victim, sel_way;
  logic [TAG_W-1:0] sel_tag;
  logic             last_beat;

  // named internal events
  logic lookup, inval_go, wt_go, alloc_go, evict_go, hit_done, wb_wr_hit, wt_done;
  logic fill_we, lru_touch;

  assign set_idx   = set_of(cpu_addr);
  assign ctag      = tag_of(cpu_addr);
  assign cword     = word_of(cpu_addr);
  assign last_beat = (beat_q == WRD_W'(LINE_WORDS - 1));

  assign inval_go  = (st_q == S_IDLE) && inval_all;
  assign lookup    = (st_q == S_IDLE) && cpu_valid && !inval_all;
  assign wt_go     = lookup && cpu_we && !wb_mode;
  assign alloc_go  = lookup && !hit && !wt_go;
  assign evict_go  = alloc_go && sel_valid && sel_dirty;
  assign hit_done  = lookup && hit && !wt_go;
  assign wb_wr_hit = hit_done && cpu_we;
  assign wt_done   = (st_q == S_WTHRU) && mem_ack;
  assign fill_we   = (st_q == S_FILL) && mem_ack && last_beat;
  assign lru_touch = hit_done || (wt_done && hit);
  assign sel_way   = (st_q == S_IDLE) ? victim : vway_q;

  cache_tagdir u_tags (
    .clk(clk), .rst_n(rst_n), .clr(inval_go), .set_idx(set_idx), .cmp_tag(ctag),
    .hit(hit), .hit_way(hit_way), .sel_way(sel_way), .sel_tag(sel_tag),
    .sel_valid(sel_valid), .sel_dirty(sel_dirty), .fill_we(fill_we),
    .dirty_we(wb_wr_hit)
  );

  cache_lru u_lru (
    .clk(clk), .rst_n(rst_n), .clr(inval_go), .set_idx(set_idx),
    .touch(lru_touch), .touch_way(hit_way), .lock_en(lock_en), .victim(victim)
  );

  assign cpu_ready = hit_done || wt_done;
  assign cpu_rdata = data_q[hit_way][set_idx][cword];

  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_EVICT) || (st_q == S_WTHRU);
  assign mem_be    = (st_q == S_WTHRU) ? cpu_be : '1;
  assign mem_wdata = (st_q == S_WTHRU) ? cpu_wdata : data_q[vway_q][set_idx][beat_q];
  always_comb begin
    case (st_q)
      S_EVICT: mem_addr = {sel_tag, set_idx, beat_q, {(OFF_W-WRD_W){1'b0}}};
      S_FILL:  mem_addr = {ctag,    set_idx, beat_q, {(OFF_W-WRD_W){1'b0}}};
      default: mem_addr = {cpu_addr[AW-1:OFF_W-WRD_W], {(OFF_W-WRD_W){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (wb_wr_hit || (wt_done && hit))
      data_q[hit_way][set_idx][cword] <=
        byte_merge(data_q[hit_way][set_idx][cword], cpu_wdata, cpu_be);
    if ((st_q == S_FILL) && mem_ack)
      data_q[vway_q][set_idx][beat_q] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      vway_q <= '0;
      beat_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          beat_q <= '0;
          if (wt_go)         st_q <= S_WTHRU;
          else if (alloc_go) begin
            vway_q <= victim;
            st_q   <= evict_go ? S_EVICT : S_FILL;
          end
        end
        S_EVICT: if (mem_ack) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) st_q <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) st_q <= S_IDLE;
        end
        default: if (mem_ack) st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk
  import cache_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            lookup,
  input logic            hit,
  input logic            cpu_we,
  input logic            cpu_ready,
  input logic            mem_req,
  input logic            mem_ack,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic            alloc_go,
  input logic            lock_en,
  input logic [WAY_W-1:0] vway_q,
  input logic            wb_wr_hit,
  input logic            inval_go
);
  p_read_hit_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && hit && !cpu_we) |-> (cpu_ready && !mem_req));

  p_done_after_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (!mem_req || mem_ack));

  p_lock_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_go && lock_en) |=> !LOCKABLE[vway_q]);

  p_wb_hit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_wr_hit |=> !mem_req);

  p_inval_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inval_go |=> !mem_req);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind cache_ctrl cache_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lookup(lookup), .hit(hit), .cpu_we(cpu_we),
  .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .alloc_go(alloc_go), .lock_en(lock_en), .vway_q(vway_q),
  .wb_wr_hit(wb_wr_hit), .inval_go(inval_go)
);

// File: tb/tb_cache_ctrl.sv
module tb_cache_ctrl;
  localparam int CLK_P = 10;
  localparam int NV    = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode = 1'b1, lock_en = 1'b0, inval_all = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [31:0] bmem [4096];
  logic [31:0] wr_log [4];
  logic [31:0] rd_log [4];

  always #(CLK_P/2) clk = ~clk;

  cache_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .lock_en(lock_en),
    .inval_all(inval_all), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] memval(input logic [11:0] wa);
    return {20'hC0DE0, wa};
  endfunction

  // memory responder: one acknowledge per beat, two cycles per beat
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) bmem[mem_addr[13:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
        wr_cnt <= wr_cnt + 1;
        wr_log[0] <= wr_log[1]; wr_log[1] <= wr_log[2];
        wr_log[2] <= wr_log[3]; wr_log[3] <= mem_addr;
      end else begin
        mem_rdata <= bmem[mem_addr[13:2]];
        rd_cnt <= rd_cnt + 1;
        rd_log[0] <= rd_log[1]; rd_log[1] <= rd_log[2];
        rd_log[2] <= rd_log[3]; rd_log[3] <= mem_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    cyc = 0;
    #1;
    while (!cpu_ready && cyc < 200) begin
      @(negedge clk); #1;
      cyc++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  // vector: we, addr[15:0], be, wdata, expected rdata, expected hit
  localparam logic [85:0] VEC [NV] = '{
    {1'b0, 16'h0058, 4'hF, 32'h0,        32'hC0DE0016, 1'b0},
    {1'b0, 16'h0054, 4'hF, 32'h0,        32'hC0DE0015, 1'b1},
    {1'b1, 16'h0054, 4'hF, 32'h11111111, 32'h0,        1'b1},
    {1'b0, 16'h0054, 4'hF, 32'h0,        32'h11111111, 1'b1},
    {1'b0, 16'h0850, 4'hF, 32'h0,        32'hC0DE0214, 1'b0},
    {1'b0, 16'h1050, 4'hF, 32'h0,        32'hC0DE0414, 1'b0},
    {1'b0, 16'h1850, 4'hF, 32'h0,        32'hC0DE0614, 1'b0},
    {1'b0, 16'h005C, 4'hF, 32'h0,        32'hC0DE0017, 1'b1},
    {1'b0, 16'h2050, 4'hF, 32'h0,        32'hC0DE0814, 1'b0},
    {1'b0, 16'h0850, 4'hF, 32'h0,        32'hC0DE0214, 1'b0},
    {1'b1, 16'h0058, 4'h3, 32'h0000ABCD, 32'h0,        1'b1},
    {1'b0, 16'h0058, 4'hF, 32'h0,        32'hC0DEABCD, 1'b1}
  };

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc, w0;
    for (int i = 0; i < 4096; i++) bmem[i] = memval(12'(i));
    repeat (3) @(negedge clk);
    chk(!cpu_ready && !mem_req, "reset", {30'b0, cpu_ready, mem_req}, 32'h0);
    rst_n = 1'b1;

    // table: hits (R1), fills (R2), LRU order (R3), write-back merges (R6)
    for (int v = 0; v < NV; v++) begin
      access(VEC[v][85], {16'h0, VEC[v][84:69]}, VEC[v][68:65], VEC[v][64:33], rd, cyc);
      chk((cyc == 0) == VEC[v][0], "R3 hit/miss", 32'(cyc), {31'b0, VEC[v][0]});
      if (!VEC[v][85]) chk(rd == VEC[v][32:1], "R1 R2 R6 data", rd, VEC[v][32:1]);
    end
    chk(wr_cnt == 0, "R6 no write traffic", 32'(wr_cnt), 32'h0);

    // dirty eviction in set 9 (R6 write allocate, R7, R2 burst order)
    access(1'b1, 32'h0094, 4'hF, 32'h12345678, rd, cyc);
    chk(cyc != 0 && wr_cnt == 0, "R6 write miss allocates", 32'(wr_cnt), 32'h0);
    access(1'b0, 32'h0890, 4'hF, 0, rd, cyc);
    access(1'b0, 32'h1090, 4'hF, 0, rd, cyc);
    access(1'b0, 32'h1890, 4'hF, 0, rd, cyc);
    w0 = wr_cnt;
    access(1'b0, 32'h2090, 4'hF, 0, rd, cyc);
    chk(wr_cnt - w0 == 4, "R7 writeback beats", 32'(wr_cnt - w0), 32'h4);
    chk(bmem[12'h025] == 32'h12345678, "R7 written data", bmem[12'h025], 32'h12345678);
    chk(wr_log[0] == 32'h90 && wr_log[3] == 32'h9C, "R7 order", wr_log[3], 32'h9C);
    chk(rd_log[0] == 32'h2090 && rd_log[1] == 32'h2094 && rd_log[3] == 32'h209C,
        "R2 fill order", rd_log[0], 32'h2090);
    chk(rd == 32'hC0DE0824, "R2 refill data", rd, 32'hC0DE0824);

    // lock in set 12 (R4, R5)
    access(1'b0, 32'h00C0, 4'hF, 0, rd, cyc);
    access(1'b0, 32'h08C0, 4'hF, 0, rd, cyc);
    lock_en = 1'b1;
    access(1'b0, 32'h10C0, 4'hF, 0, rd, cyc);
    access(1'b0, 32'h18C0, 4'hF, 0, rd, cyc);
    access(1'b0, 32'h20C0, 4'hF, 0, rd, cyc);
    access(1'b0, 32'h00C0, 4'hF, 0, rd, cyc);
    chk(cyc == 0 && rd == 32'hC0DE0030, "R5 locked way hit", rd, 32'hC0DE0030);
    access(1'b0, 32'h08C0, 4'hF, 0, rd, cyc);
    chk(cyc == 0, "R5 locked way hit", 32'(cyc), 32'h0);
    access(1'b0, 32'h18C0, 4'hF, 0, rd, cyc);
    chk(cyc == 0, "R4 other unlocked way kept", 32'(cyc), 32'h0);
    access(1'b0, 32'h10C0, 4'hF, 0, rd, cyc);
    chk(cyc != 0, "R4 unlocked LRU evicted", 32'(cyc), 32'h1);
    lock_en = 1'b0;

    // write-through in set 20 (R8)
    wb_mode = 1'b0;
    w0 = wr_cnt;
    access(1'b1, 32'h0140, 4'hF, 32'h55555555, rd, cyc);
    chk(wr_cnt - w0 == 1 && bmem[12'h050] == 32'h55555555, "R8 write-through",
        bmem[12'h050], 32'h55555555);
    access(1'b0, 32'h0140, 4'hF, 0, rd, cyc);
    chk(cyc != 0 && rd == 32'h55555555, "R8 no allocate", 32'(cyc), 32'h1);
    access(1'b1, 32'h0140, 4'h8, 32'hAA000000, rd, cyc);
    chk(bmem[12'h050] == 32'hAA555555, "R8 byte enables", bmem[12'h050], 32'hAA555555);
    access(1'b0, 32'h0140, 4'hF, 0, rd, cyc);
    chk(cyc == 0 && rd == 32'hAA555555, "R8 hit updated", rd, 32'hAA555555);
    wb_mode = 1'b1;

    // invalidate drops dirty data (R9)
    access(1'b1, 32'h2090, 4'hF, 32'hDEADBEEF, rd, cyc);
    w0 = wr_cnt;
    @(negedge clk); inval_all = 1'b1;
    @(negedge clk); inval_all = 1'b0;
    access(1'b0, 32'h2090, 4'hF, 0, rd, cyc);
    chk(cyc != 0 && rd == 32'hC0DE0824, "R9 invalidated", rd, 32'hC0DE0824);
    chk(wr_cnt == w0, "R9 no writeback", 32'(wr_cnt - w0), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule